// File: doc/BRIEF.md
# Run-Time Programmable Trigger Condition Evaluator

This block watches a group of equal-width monitored signals. On every clock it decides whether a condition, programmed at run time, holds on the values sampled at that edge. Each signal lane has one term. A term has an enable, an operator code, a reference value and a don't-care mask. Lanes can be tested by unsigned value, by the level of their bit 0, or for a rising edge on bit 0. All enabled terms are combined with one operator for the whole condition: either every term must hold, or any term is enough.

Control is a two-state machine. In `ST_IDLE` the term registers can be written one lane at a time. The transition `ST_IDLE -> ST_ARMED` is taken when `arm_i` is high, and it latches the combination mode from `arm_or_i`. In `ST_ARMED` the writes are ignored and the condition is evaluated every cycle. The transition `ST_ARMED -> ST_IDLE` is taken when the condition holds, which also raises `trig_o` for exactly one cycle. The same transition is taken when `disarm_i` is high and the condition does not hold. The evaluator is therefore single-shot: it must be armed again for each trigger.

Top module: `trig_cond_eval`

## Requirements
- R1: While reset is active and directly after it, `trig_o` and `armed_o` are 0, every term is disabled, and both the sample register and the previous-sample register of every lane hold 0.
- R2: A write with `cfg_we_i` high updates lane `cfg_sel_i` only in `ST_IDLE`. A write presented in `ST_ARMED` has no effect, either now or after a later re-arm.
- R3: `arm_i` in `ST_IDLE` makes `armed_o` high on the next cycle. `disarm_i` in `ST_ARMED` returns to `ST_IDLE` on the next cycle if no match is present. `disarm_i` has no effect in `ST_IDLE`.
- R4: Values presented on `sig_i` before clock edge k are sampled at edge k. A match on those values while armed raises `trig_o` after edge k+1 for exactly one cycle. At that same edge the block returns to `ST_IDLE`, so a condition that keeps holding gives only one pulse.
- R5: Op 0 (equal) and op 1 (not equal) compare the lane with its reference. Bits whose mask bit is 1 are don't-care: reference 101 with mask 010 matches both 101 and 111.
- R6: Op 2 (>), op 3 (>=), op 4 (<) and op 5 (<=) compare the lane with its reference as unsigned numbers, using every bit. The mask has no effect on these ops.
- R7: Op 6 (high) holds when bit 0 of the lane is 1. Op 7 (low) holds when bit 0 is 0.
- R8: Op 8 (rising) holds when bit 0 of the lane was 0 in the previous sample and is 1 in the current one.
- R9: With `arm_or_i` = 0 latched at arm, the condition holds only when every enabled term is true in the same cycle.
- R10: With `arm_or_i` = 1 latched at arm, the condition holds when at least one enabled term is true.
- R11: With no term enabled, the condition holds on the first armed cycle in either mode.
- R12: Op codes 9 to 15 make a term that is always false.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sig_i | input | NUM_SIG*SIG_W | Monitored lanes; lane i occupies bits [i*SIG_W +: SIG_W] |
| cfg_we_i | input | 1 | Term write strobe |
| cfg_sel_i | input | SEL_W | Lane number to write |
| cfg_en_i | input | 1 | Term enable to write |
| cfg_op_i | input | 4 | Operator code to write |
| cfg_ref_i | input | SIG_W | Reference value to write |
| cfg_dcm_i | input | SIG_W | Don't-care mask to write (1 = ignore bit) |
| arm_i | input | 1 | Start evaluation |
| arm_or_i | input | 1 | Combination mode latched at arm: 0 all-terms, 1 any-term |
| disarm_i | input | 1 | Abandon evaluation |
| armed_o | output | 1 | High in `ST_ARMED` |
| trig_o | output | 1 | Single-cycle match pulse |

## Verification
Inputs are driven on the falling edge and sampled at the next rising edge. For every driven cycle, the driver works out the expected `trig_o` and `armed_o` from a model of the requirements. It pushes that expectation with a due cycle one rising edge later. This is the point where the evaluation of the previous sample and the state update both appear. The lane values just driven are therefore judged a cycle after that. The monitor pops each item on the falling edge of its due cycle, so a pulse one cycle early, one cycle late or repeated is reported against the requirement being exercised.

// File: rtl/trig_pkg.sv
package trig_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } trig_state_e;

    localparam logic [3:0] OP_EQ   = 4'd0;
    localparam logic [3:0] OP_NE   = 4'd1;
    localparam logic [3:0] OP_GT   = 4'd2;
    localparam logic [3:0] OP_GE   = 4'd3;
    localparam logic [3:0] OP_LT   = 4'd4;
    localparam logic [3:0] OP_LE   = 4'd5;
    localparam logic [3:0] OP_HIGH = 4'd6;
    localparam logic [3:0] OP_LOW  = 4'd7;
    localparam logic [3:0] OP_RISE = 4'd8;

endpackage

// File: rtl/trig_term_cmp.sv
module trig_term_cmp
    import trig_pkg::*;
#(
    parameter int SIG_W = 8
) (
    input  logic [SIG_W-1:0] cur_i,
    input  logic             prev_b0_i,
    input  logic [3:0]       op_i,
    input  logic [SIG_W-1:0] ref_i,
    input  logic [SIG_W-1:0] dcm_i,
    output logic             hit_o
);

    logic eq_masked;

    // don't-care bits are removed only from the equality test
    assign eq_masked = ((cur_i ^ ref_i) & ~dcm_i) == '0;

    always_comb begin
        unique case (op_i)
            OP_EQ:   hit_o = eq_masked;
            OP_NE:   hit_o = !eq_masked;
            OP_GT:   hit_o = cur_i >  ref_i;
            OP_GE:   hit_o = cur_i >= ref_i;
            OP_LT:   hit_o = cur_i <  ref_i;
            OP_LE:   hit_o = cur_i <= ref_i;
            OP_HIGH: hit_o = cur_i[0];
            OP_LOW:  hit_o = !cur_i[0];
            OP_RISE: hit_o = !prev_b0_i && cur_i[0];
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/trig_combine.sv
module trig_combine #(
    parameter int NUM_SIG = 4
) (
    input  logic [NUM_SIG-1:0] hit_i,
    input  logic [NUM_SIG-1:0] en_i,
    input  logic               or_mode_i,
    output logic               match_o
);

    logic all_true;
    logic any_true;
    logic none_en;

    assign all_true = &(hit_i | ~en_i);
    assign any_true = |(hit_i & en_i);
    assign none_en  = ~|en_i;

    assign match_o = none_en || (or_mode_i ? any_true : all_true);

endmodule

// File: rtl/trig_cond_eval.sv
module trig_cond_eval
    import trig_pkg::*;
#(
    parameter int NUM_SIG = 4,
    parameter int SIG_W   = 8,
    localparam int SEL_W  = (NUM_SIG > 1) ? $clog2(NUM_SIG) : 1,
    localparam int BUS_W  = NUM_SIG * SIG_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [BUS_W-1:0] sig_i,
    input  logic             cfg_we_i,
    input  logic [SEL_W-1:0] cfg_sel_i,
    input  logic             cfg_en_i,
    input  logic [3:0]       cfg_op_i,
    input  logic [SIG_W-1:0] cfg_ref_i,
    input  logic [SIG_W-1:0] cfg_dcm_i,
    input  logic             arm_i,
    input  logic             arm_or_i,
    input  logic             disarm_i,
    output logic             armed_o,
    output logic             trig_o
);

    trig_state_e state_q;
    trig_state_e state_d;

    logic [NUM_SIG-1:0]            en_q;
    logic [NUM_SIG-1:0][3:0]       op_q;
    logic [NUM_SIG-1:0][SIG_W-1:0] ref_q;
    logic [NUM_SIG-1:0][SIG_W-1:0] dcm_q;
    logic                          or_mode_q;

    logic [BUS_W-1:0]   cur_q;
    logic [NUM_SIG-1:0] prev_b0_q;
    logic [NUM_SIG-1:0] hit;
    logic               match;
    logic               trig_q;
    logic               sel_ok;

    assign sel_ok = int'(cfg_sel_i) < NUM_SIG;

    // sample stage: current lane values and bit-0 history (R1, R8)
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cur_q     <= '0;
            prev_b0_q <= '0;
        end else begin
            cur_q <= sig_i;
            for (int i = 0; i < NUM_SIG; i++) begin
                prev_b0_q[i] <= cur_q[i*SIG_W];
            end
        end
    end

    // term registers: writable only while idle (R2)
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            en_q      <= '0;
            op_q      <= '0;
            ref_q     <= '0;
            dcm_q     <= '0;
            or_mode_q <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            if (cfg_we_i && sel_ok) begin
                en_q[cfg_sel_i]  <= cfg_en_i;
                op_q[cfg_sel_i]  <= cfg_op_i;
                ref_q[cfg_sel_i] <= cfg_ref_i;
                dcm_q[cfg_sel_i] <= cfg_dcm_i;
            end
            if (arm_i) begin
                or_mode_q <= arm_or_i;
            end
        end
    end

    for (genvar g = 0; g < NUM_SIG; g++) begin : g_term
        trig_term_cmp #(
            .SIG_W (SIG_W)
        ) u_cmp (
            .cur_i     (cur_q[g*SIG_W +: SIG_W]),
            .prev_b0_i (prev_b0_q[g]),
            .op_i      (op_q[g]),
            .ref_i     (ref_q[g]),
            .dcm_i     (dcm_q[g]),
            .hit_o     (hit[g])
        );
    end

    trig_combine #(
        .NUM_SIG (NUM_SIG)
    ) u_comb (
        .hit_i     (hit),
        .en_i      (en_q),
        .or_mode_i (or_mode_q),
        .match_o   (match)
    );

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (arm_i) state_d = ST_ARMED;
            ST_ARMED: if (match || disarm_i) state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            trig_q <= 1'b0;
        end else begin
            trig_q <= (state_q == ST_ARMED) && match;
        end
    end

    assign trig_o  = trig_q;
    assign armed_o = (state_q == ST_ARMED);

    AST_ARM_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(armed_o) |-> $past(arm_i)); // R3

    AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_o |=> !trig_o); // R4

    AST_PULSE_ENDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_o |-> !armed_o); // R4

    AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_o |=> ($stable(en_q) && $stable(op_q) && $stable(ref_q) && $stable(dcm_q))); // R2

    AST_EMPTY_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_o && (en_q == '0)) |=> trig_o); // R11

endmodule

// File: tb/trig_cond_eval_tb.sv
`timescale 1ns/1ps
module trig_cond_eval_tb;

    localparam int NS = 4;
    localparam int SW = 8;
    localparam int W  = NS * SW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  sig_i = '0;
    logic          cfg_we_i = 1'b0;
    logic [1:0]    cfg_sel_i = '0;
    logic          cfg_en_i = 1'b0;
    logic [3:0]    cfg_op_i = '0;
    logic [SW-1:0] cfg_ref_i = '0;
    logic [SW-1:0] cfg_dcm_i = '0;
    logic          arm_i = 1'b0;
    logic          arm_or_i = 1'b0;
    logic          disarm_i = 1'b0;
    logic          armed_o;
    logic          trig_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    trig_cond_eval #(.NUM_SIG(NS), .SIG_W(SW)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .sig_i(sig_i),
        .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_en_i(cfg_en_i),
        .cfg_op_i(cfg_op_i), .cfg_ref_i(cfg_ref_i), .cfg_dcm_i(cfg_dcm_i),
        .arm_i(arm_i), .arm_or_i(arm_or_i), .disarm_i(disarm_i),
        .armed_o(armed_o), .trig_o(trig_o)
    );

    // scoreboard queues
    int    q_due[$];
    logic  q_trig[$];
    logic  q_arm[$];
    string q_tag[$];

    // requirement model
    logic          m_state = 1'b0;
    logic          m_or = 1'b0;
    logic          m_en [NS];
    logic [3:0]    m_op [NS];
    logic [SW-1:0] m_ref [NS];
    logic [SW-1:0] m_dcm [NS];
    logic [W-1:0]  m_cur = '0;
    logic [W-1:0]  m_prev = '0;
    logic [W-1:0]  hold = '0;

    function automatic logic term_true(int i);
        logic [SW-1:0] c;
        logic [SW-1:0] p;
        logic eq;
        c  = m_cur[i*SW +: SW];
        p  = m_prev[i*SW +: SW];
        eq = ((c ^ m_ref[i]) & ~m_dcm[i]) == '0;
        case (m_op[i])
            4'd0: return eq;              // R5
            4'd1: return !eq;             // R5
            4'd2: return c > m_ref[i];    // R6
            4'd3: return c >= m_ref[i];
            4'd4: return c < m_ref[i];
            4'd5: return c <= m_ref[i];
            4'd6: return c[0];            // R7
            4'd7: return !c[0];
            4'd8: return !p[0] && c[0];   // R8
            default: return 1'b0;         // R12
        endcase
    endfunction

    function automatic logic model_hit();
        logic any_t;
        logic all_t;
        logic none;
        logic t;
        any_t = 1'b0;
        all_t = 1'b1;
        none  = 1'b1;
        for (int i = 0; i < NS; i++) begin
            if (m_en[i]) begin
                t = term_true(i);
                none  = 1'b0;
                any_t = any_t | t;
                all_t = all_t & t;
            end
        end
        return none | (m_or ? any_t : all_t); // R9 R10 R11
    endfunction

    task automatic step(input logic a, input logic d, input logic [W-1:0] s, input string tag);
        logic h;
        logic ns;
        h = model_hit();
        if (!m_state) ns = a;
        else          ns = (h || d) ? 1'b0 : 1'b1;
        q_due.push_back(cyc + 1);
        q_trig.push_back(m_state & h);
        q_arm.push_back(ns);
        q_tag.push_back(tag);
        if (!m_state && cfg_we_i) begin
            m_en[cfg_sel_i]  = cfg_en_i;
            m_op[cfg_sel_i]  = cfg_op_i;
            m_ref[cfg_sel_i] = cfg_ref_i;
            m_dcm[cfg_sel_i] = cfg_dcm_i;
        end
        if (!m_state && a) m_or = arm_or_i;
        m_prev  = m_cur;
        m_cur   = s;
        m_state = ns;
        arm_i    = a;
        disarm_i = d;
        sig_i    = s;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic wr(input int idx, input logic en, input logic [3:0] op,
                      input logic [SW-1:0] rf, input logic [SW-1:0] dm, input string tag);
        cfg_sel_i = idx[1:0];
        cfg_en_i  = en;
        cfg_op_i  = op;
        cfg_ref_i = rf;
        cfg_dcm_i = dm;
        cfg_we_i  = 1'b1;
        step(1'b0, 1'b0, hold, tag);
    endtask

    task automatic run(input logic [W-1:0] s, input string tag);
        hold = s;
        step(1'b0, 1'b0, s, tag);
    endtask

    task automatic armit(input logic orm, input logic [W-1:0] s, input string tag);
        arm_or_i = orm;
        hold = s;
        step(1'b1, 1'b0, s, tag);
    endtask

    task automatic dis(input string tag);
        step(1'b0, 1'b1, hold, tag);
    endtask

    // monitor
    always @(negedge clk) begin
        while (q_due.size() > 0 && q_due[0] == cyc) begin
            checks++;
            if (trig_o !== q_trig[0] || armed_o !== q_arm[0]) begin
                errors++;
                $display("FAIL %s: cycle %0d trig_o=%b expected %b, armed_o=%b expected %b",
                         q_tag[0], cyc, trig_o, q_trig[0], armed_o, q_arm[0]);
            end
            void'(q_due.pop_front());
            void'(q_trig.pop_front());
            void'(q_arm.pop_front());
            void'(q_tag.pop_front());
        end
    end

    initial begin
        for (int i = 0; i < NS; i++) begin
            m_en[i] = 1'b0; m_op[i] = '0; m_ref[i] = '0; m_dcm[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        checks++; // R1 reset state
        if (trig_o !== 1'b0 || armed_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: trig_o=%b armed_o=%b expected 0 0", trig_o, armed_o);
        end

        // R11 empty condition fires at once, R3 arm
        armit(1'b0, 32'h0, "R11");
        run(32'h0, "R11");
        run(32'h0, "R1");
        dis("R3"); // disarm while idle: no effect

        // R5 equality with don't-care bit 1, R4 single pulse
        wr(0, 1'b1, 4'd0, 8'h05, 8'h02, "R5");
        armit(1'b0, 32'h04, "R3");
        run(32'h04, "R5");
        run(32'h05, "R5");
        run(32'h05, "R4");
        run(32'h05, "R4");
        armit(1'b0, 32'h07, "R5");
        run(32'h07, "R5");
        run(32'h07, "R5");
        wr(0, 1'b1, 4'd1, 8'h05, 8'h02, "R5");
        armit(1'b0, 32'h07, "R5");
        run(32'h07, "R5");
        run(32'h06, "R5");
        run(32'h06, "R5");

        // R6 unsigned ordering, mask ignored
        wr(0, 1'b1, 4'd2, 8'h7F, 8'hFF, "R6");
        armit(1'b0, 32'h7F, "R6");
        run(32'h7F, "R6");
        run(32'h80, "R6");
        run(32'h80, "R6");
        wr(0, 1'b1, 4'd3, 8'h80, 8'hFF, "R6");
        armit(1'b0, 32'h7F, "R6");
        run(32'h80, "R6");
        run(32'h80, "R6");
        wr(0, 1'b1, 4'd4, 8'h10, 8'h00, "R6");
        armit(1'b0, 32'h10, "R6");
        run(32'h0F, "R6");
        run(32'h0F, "R6");
        wr(0, 1'b1, 4'd5, 8'h10, 8'h00, "R6");
        armit(1'b0, 32'h11, "R6");
        run(32'h10, "R6");
        run(32'h10, "R6");

        // R7 level tests on lane 1
        wr(0, 1'b0, 4'd0, 8'h00, 8'h00, "R7");
        wr(1, 1'b1, 4'd6, 8'h00, 8'h00, "R7");
        armit(1'b0, 32'h0000_FE00, "R7");
        run(32'h0000_FE00, "R7");
        run(32'h0000_0100, "R7");
        run(32'h0000_0100, "R7");
        wr(1, 1'b1, 4'd7, 8'h00, 8'h00, "R7");
        armit(1'b0, 32'h0000_0100, "R7");
        run(32'h0000_0300, "R7");
        run(32'h0000_0200, "R7");
        run(32'h0000_0200, "R7");

        // R8 rising edge on lane 2
        wr(1, 1'b0, 4'd0, 8'h00, 8'h00, "R8");
        wr(2, 1'b1, 4'd8, 8'h00, 8'h00, "R8");
        run(32'h0001_0000, "R8");
        armit(1'b0, 32'h0001_0000, "R8");
        run(32'h0001_0000, "R8");
        run(32'h0000_0000, "R8");
        run(32'h0001_0000, "R8");
        run(32'h0001_0000, "R8");

        // R9 all-terms mode
        wr(2, 1'b0, 4'd0, 8'h00, 8'h00, "R9");
        wr(0, 1'b1, 4'd0, 8'h33, 8'h00, "R9");
        wr(3, 1'b1, 4'd3, 8'h40, 8'h00, "R9");
        armit(1'b0, 32'h0000_0033, "R9");
        run(32'h4000_0000, "R9");
        run(32'h4000_0033, "R9");
        run(32'h4000_0033, "R9");

        // R10 any-term mode
        armit(1'b1, 32'h1000_0000, "R10");
        run(32'h1000_0033, "R10");
        run(32'h1000_0033, "R10");
        armit(1'b1, 32'h0000_0000, "R10");
        run(32'h4100_0000, "R10");
        run(32'h4100_0000, "R10");

        // R2 writes while armed ignored, R3 disarm
        armit(1'b0, 32'h0000_0033, "R2");
        cfg_sel_i = 2'd3; cfg_en_i = 1'b1; cfg_op_i = 4'd3;
        cfg_ref_i = 8'h00; cfg_dcm_i = 8'h00; cfg_we_i = 1'b1;
        step(1'b0, 1'b0, hold, "R2");
        run(32'h0000_0033, "R2");
        run(32'h0000_0033, "R2");
        dis("R3");
        run(32'h0000_0033, "R3");
        armit(1'b0, 32'h0000_0033, "R2");
        run(32'h0000_0033, "R2");
        run(32'h0000_0033, "R2");
        dis("R3");

        // R12 undefined op code
        wr(3, 1'b0, 4'd0, 8'h00, 8'h00, "R12");
        wr(0, 1'b1, 4'd9, 8'h00, 8'h00, "R12");
        armit(1'b0, 32'h0, "R12");
        run(32'h0, "R12");
        run(32'hFF, "R12");
        dis("R12");
        run(32'h0, "R12");
        run(32'h0, "R12");

        repeat (3) @(negedge clk);
        checks++;
        if (q_due.size() != 0) begin
            errors++;
            $display("FAIL R4: %0d expected results never compared, expected 0", q_due.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule